// File: doc/BRIEF.md
# Interval Timer with One-Shot and Periodic Modes

This block is a 32-bit interval timer that is set up and watched through a small synchronous register bus. Software writes an interval, picks one-shot or periodic operation and a count direction, and then sets the enable bit. Counting down starts from the interval value. Counting up starts from zero. Either way, the timer times out after interval+1 running cycles.

At each time-out the block sends a one-cycle pulse on `trig_out`. That pulse can start the next timer in a chain. A timer that is set to wait for a trigger stays armed until `trig_in` pulses. Time-outs can set a sticky status flag, which software clears by writing a one to it. The interrupt output is the status flag gated by a mask bit. In periodic mode, an optional snapshot records the number of cycles the timer has run since it was enabled, captured at each time-out.

Top module: `ivt_timer`

## Requirements
- R1: After reset, SETUP (address 0) reads 0x20, LOAD (address 1), CTRL (address 2), MASK (address 3) and RAW (address 4) read 0, and `irq` and `trig_out` are low.
- R2: SETUP holds the mode in bits [1:0] (1 = one-shot, 2 = periodic), the up-count flag in bit 2, wait-for-trigger in bit 3, snapshot in bit 4 and time-out-status disable in bit 5. A write to SETUP is ignored while CTRL bit 0 (enable) is 1.
- R3: With bit 2 clear, writing CTRL bit 0 = 1 loads the counter with LOAD. The counter then decrements once per cycle, and a time-out occurs in the cycle where it reads 0, which is LOAD+1 cycles after the enable write.
- R4: With bit 2 set, enabling clears the counter to 0. The counter then increments once per cycle, and a time-out occurs when it equals LOAD, which is LOAD+1 cycles after enabling.
- R5: In periodic mode the counter reloads at each time-out (to LOAD when counting down, to 0 when counting up) and keeps running, so time-outs repeat every LOAD+1 cycles.
- R6: In one-shot mode the timer stops at the first time-out, CTRL bit 0 clears, and VALUE (address 7) holds the terminal count: 0 when counting down, LOAD when counting up.
- R7: With wait-for-trigger set, an enabled timer does not count until `trig_in` is high for a cycle. The first time-out then follows LOAD+1 cycles after that trigger.
- R8: `trig_out` goes high for one cycle at each time-out.
- R9: While SETUP bit 5 is 1, time-outs do not set RAW bit 0.
- R10: Writing 1 to ICLR (address 6) bit 0 clears RAW bit 0. A time-out in the same cycle takes priority and leaves the flag set.
- R11: MSTAT (address 5) equals RAW AND MASK, and `irq` is high exactly when MSTAT bit 0 is 1.
- R12: In periodic mode with the snapshot bit set, VALUE returns the number of running cycles since enable, captured at the last time-out (LOAD at the first time-out, 2·LOAD+1 at the second). Otherwise VALUE returns the live counter.
- R13: With mode 0 or 3 the enabled counter stays frozen at its loaded value and no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_in | input | 1 | Start pulse from the previous timer in the chain |
| trig_out | output | 1 | One-cycle pulse at each time-out |
| irq | output | 1 | Level interrupt from the masked status |

## Verification
The hardest case to reach is a time-out that lands in the same cycle as an interrupt-clear write. The bench forces this with a periodic interval of zero, which makes every running cycle a time-out, so any clear write must collide with a set. Wait-for-trigger is another hard case: the bench holds the timer armed for many cycles while checking that `trig_out` stays silent and the count stays at its loaded value. It then measures the time to the first time-out from the edge where the trigger was taken. The snapshot case needs two consecutive periodic time-outs, because only the second one separates a free-running capture from a simple reload value.

// File: rtl/ivt_pkg.sv
// Shared types for the interval timer: register indices, run modes and
// the packed layout of the setup register. Assumes a word-indexed bus.
package ivt_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SETUP = 3'd0,
        A_LOAD  = 3'd1,
        A_CTRL  = 3'd2,
        A_MASK  = 3'd3,
        A_RAW   = 3'd4,
        A_MSTAT = 3'd5,
        A_ICLR  = 3'd6,
        A_VALUE = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_ONESHOT  = 2'd1,
        M_PERIODIC = 2'd2,
        M_RSVD     = 2'd3
    } run_mode_e;

    // Bit 5 tid, bit 4 snap, bit 3 wot, bit 2 up, bits 1:0 mode
    typedef struct packed {
        logic      tid;
        logic      snap;
        logic      wot;
        logic      up;
        run_mode_e mode;
    } setup_t;

    localparam int SETUP_W = $bits(setup_t);
    localparam setup_t SETUP_RST = '{tid: 1'b1, snap: 1'b0, wot: 1'b0,
                                     up: 1'b0, mode: M_IDLE};
endpackage

// File: rtl/ivt_regs.sv
// Register file and bus decode. Holds setup, interval, enable and mask.
// Setup is locked while enabled; a one-shot completion clears the enable.
// Assumes CNT_W <= DATA_W and single-cycle, always-ready bus accesses.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done_i,
    input  logic              raw_i,
    input  logic              mstat_i,
    input  logic [CNT_W-1:0]  value_i,
    output setup_t            setup_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              en_o,
    output logic              start_o,
    output logic              mask_o,
    output logic              iclr_o
);
    setup_t             setup_q;
    logic [CNT_W-1:0]   load_q;
    logic               en_q;
    logic               mask_q;
    logic               wr_en;

    assign wr_en   = bus_sel && bus_wr;
    assign start_o = wr_en && (bus_addr == A_CTRL) && bus_wdata[0] && !en_q;
    assign iclr_o  = wr_en && (bus_addr == A_ICLR) && bus_wdata[0];

    // Setup register: writable only while the timer is disabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            setup_q <= SETUP_RST;
        else if (wr_en && bus_addr == A_SETUP && !en_q)
            setup_q <= setup_t'(bus_wdata[SETUP_W-1:0]);
    end

    // Interval register: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '0;
        else if (wr_en && bus_addr == A_LOAD)
            load_q <= bus_wdata[CNT_W-1:0];
    end

    // Enable bit: one-shot completion overrides a bus write
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (done_i)
            en_q <= 1'b0;
        else if (wr_en && bus_addr == A_CTRL)
            en_q <= bus_wdata[0];
    end

    // Interrupt mask bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b0;
        else if (wr_en && bus_addr == A_MASK)
            mask_q <= bus_wdata[0];
    end

    // Read multiplexer, zero-extended to the bus width
    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            A_SETUP: bus_rdata[SETUP_W-1:0] = setup_q;
            A_LOAD:  bus_rdata[CNT_W-1:0]   = load_q;
            A_CTRL:  bus_rdata[0]           = en_q;
            A_MASK:  bus_rdata[0]           = mask_q;
            A_RAW:   bus_rdata[0]           = raw_i;
            A_MSTAT: bus_rdata[0]           = mstat_i;
            A_ICLR:  bus_rdata              = '0;
            A_VALUE: bus_rdata[CNT_W-1:0]   = value_i;
            default: bus_rdata              = '0;
        endcase
    end

    assign setup_o = setup_q;
    assign load_o  = load_q;
    assign en_o    = en_q;
    assign mask_o  = mask_q;

    assert_setup_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(setup_q));

    assert_oneshot_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !en_q);
endmodule

// File: rtl/ivt_count.sv
// Counter datapath: down/up counting, reload or stop at time-out,
// wait-for-trigger arming, chain trigger output and free-running snapshot.
// Assumes setup is stable while enabled (enforced by ivt_regs).
module ivt_count
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  setup_t           setup_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             trig_in,
    output logic             timeout_o,
    output logic             done_o,
    output logic             trig_out,
    output logic [CNT_W-1:0] value_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] free_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] restart_val;
    logic             wait_q;
    logic             trig_q;
    logic             mode_ok;
    logic             periodic;
    logic             run;
    logic             terminal;

    assign periodic    = (setup_i.mode == M_PERIODIC);
    assign mode_ok     = periodic || (setup_i.mode == M_ONESHOT);
    assign run         = en_i && !wait_q && mode_ok;
    assign restart_val = setup_i.up ? '0 : load_i;
    assign terminal    = setup_i.up ? (cnt_q == load_i) : (cnt_q == '0);
    assign timeout_o   = run && terminal;
    assign done_o      = timeout_o && !periodic;

    // Main counter: arm on start, step while running, reload or hold at end
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= restart_val;
        else if (run) begin
            if (terminal) begin
                if (periodic)
                    cnt_q <= restart_val;
            end else if (setup_i.up)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Arming flag for wait-for-trigger starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= 1'b0;
        else if (start_i)
            wait_q <= setup_i.wot;
        else if (en_i && trig_in)
            wait_q <= 1'b0;
    end

    // Free-running cycle count since enable, not touched by reloads
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_q <= '0;
        else if (start_i)
            free_q <= '0;
        else if (run)
            free_q <= free_q + 1'b1;
    end

    // Snapshot capture at each periodic time-out
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (timeout_o && periodic && setup_i.snap)
            snap_q <= free_q;
    end

    // Registered chain pulse, one cycle per time-out
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= 1'b0;
        else
            trig_q <= timeout_o;
    end

    assign trig_out = trig_q;
    assign value_o  = (periodic && setup_i.snap) ? snap_q : cnt_q;

    assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !setup_i.up && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && setup_i.up && cnt_q != load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && periodic && !setup_i.up) |=> (cnt_q == $past(load_i)));

    assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wait_q && !trig_in) |=> ($stable(cnt_q) && !trig_out));

    assert_frozen_mode_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !mode_ok && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ivt_stat.sv
// Time-out status flag with write-one-to-clear, mask gating and the level
// interrupt. Assumes time-out is a single-cycle strobe from the counter.
module ivt_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_i,
    input  logic tid_i,
    input  logic iclr_i,
    input  logic mask_i,
    output logic raw_o,
    output logic mstat_o,
    output logic irq
);
    logic raw_q;
    logic set_evt;

    assign set_evt = timeout_i && !tid_i;

    // Sticky raw flag: a new time-out wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (set_evt)
            raw_q <= 1'b1;
        else if (iclr_i)
            raw_q <= 1'b0;
    end

    assign raw_o   = raw_q;
    assign mstat_o = raw_q && mask_i;
    assign irq     = mstat_o;

    assert_tid_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tid_i && !raw_q) |=> !raw_q);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr_i && !timeout_i) |=> !raw_q);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> raw_q);
endmodule

// File: rtl/ivt_timer.sv
// Top of the interval timer: wires the register file, counter datapath
// and status logic. Assumes a single clock domain and synchronous reset.
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_in,
    output logic              trig_out,
    output logic              irq
);
    setup_t           setup;
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] value;
    logic             en;
    logic             start;
    logic             mask;
    logic             iclr;
    logic             timeout;
    logic             done;
    logic             raw;
    logic             mstat;

    ivt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_i    (done),
        .raw_i     (raw),
        .mstat_i   (mstat),
        .value_i   (value),
        .setup_o   (setup),
        .load_o    (load),
        .en_o      (en),
        .start_o   (start),
        .mask_o    (mask),
        .iclr_o    (iclr)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_i   (setup),
        .load_i    (load),
        .en_i      (en),
        .start_i   (start),
        .trig_in   (trig_in),
        .timeout_o (timeout),
        .done_o    (done),
        .trig_out  (trig_out),
        .value_o   (value)
    );

    ivt_stat u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .timeout_i (timeout),
        .tid_i     (setup.tid),
        .iclr_i    (iclr),
        .mask_i    (mask),
        .raw_o     (raw),
        .mstat_o   (mstat),
        .irq       (irq)
    );
endmodule

// File: tb/sim_ivt_timer.sv
`timescale 1ns/1ps
module sim_ivt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic        trig_out;
    logic        irq;
    int          nchk = 0;
    int          nfail = 0;

    always #5 clk = ~clk;

    ivt_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .trig_out(trig_out), .irq(irq)
    );

    // setup[53:48], load[47:16], expected period[15:0]
    localparam logic [53:0] VECS [0:6] = '{
        {6'h02, 32'd5, 16'd6},
        {6'h06, 32'd5, 16'd6},
        {6'h02, 32'd0, 16'd1},
        {6'h06, 32'd0, 16'd1},
        {6'h01, 32'd9, 16'd10},
        {6'h05, 32'd2, 16'd3},
        {6'h06, 32'd7, 16'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_trig(output int k);
        k = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (trig_out) break;
        end
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k;
        int quiet;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, d); check("R1 setup", d, 32'h20);
        rd(3'd1, d); check("R1 load", d, 0);
        rd(3'd2, d); check("R1 ctrl", d, 0);
        rd(3'd3, d); check("R1 mask", d, 0);
        rd(3'd4, d); check("R1 raw", d, 0);
        check("R1 irq", irq, 0);
        check("R1 trig_out", trig_out, 0);

        // Table walk: R3 R4 R5 R6 R11
        for (int v = 0; v < 7; v++) begin
            logic [5:0]  su;
            logic [31:0] ld;
            logic [15:0] per;
            {su, ld, per} = VECS[v];
            wr(3'd2, 0);
            wr(3'd6, 1);
            wr(3'd3, 1);
            wr(3'd0, {26'd0, su});
            wr(3'd1, ld);
            wr(3'd2, 1);
            wait_trig(k);
            check(su[2] ? "R4 first period up" : "R3 first period down", k, per);
            rd(3'd4, d); check("R11 raw after timeout", d, 1);
            check("R11 irq", irq, 1);
            if (su[1:0] == 2'd2) begin
                wait_trig(k);
                check("R5 periodic repeat", k, per);
            end else begin
                rd(3'd2, d); check("R6 enable cleared", d, 0);
                rd(3'd7, d); check("R6 terminal value", d, su[2] ? ld : 0);
            end
        end
        wr(3'd2, 0);
        wr(3'd6, 1);

        // R2: setup lock while enabled
        wr(3'd1, 100);
        wr(3'd0, 32'h02);
        wr(3'd2, 1);
        wr(3'd0, 32'h05);
        rd(3'd0, d); check("R2 locked write ignored", d, 32'h02);
        wr(3'd2, 0);
        wr(3'd0, 32'h05);
        rd(3'd0, d); check("R2 write while disabled", d, 32'h05);

        // R9 and R8: status disabled, pulse still emitted for one cycle
        wr(3'd3, 1);
        wr(3'd0, 32'h22);
        wr(3'd1, 2);
        wr(3'd2, 1);
        wait_trig(k);
        check("R8 pulse timing", k, 3);
        @(posedge clk); @(negedge clk);
        check("R8 one cycle pulse", trig_out, 0);
        rd(3'd4, d); check("R9 raw stays clear", d, 0);
        check("R9 irq low", irq, 0);
        wr(3'd2, 0);

        // R11 and R10: mask gating and clear
        wr(3'd3, 0);
        wr(3'd0, 32'h02);
        wr(3'd1, 1);
        wr(3'd2, 1);
        wait_trig(k);
        rd(3'd4, d); check("R11 raw set", d, 1);
        rd(3'd5, d); check("R11 masked off", d, 0);
        check("R11 irq masked", irq, 0);
        wr(3'd3, 1);
        rd(3'd5, d); check("R11 masked on", d, 1);
        check("R11 irq on", irq, 1);
        wr(3'd2, 0);
        wr(3'd6, 1);
        rd(3'd4, d); check("R10 cleared", d, 0);
        check("R10 irq low", irq, 0);

        // R10: a time-out in the same cycle as a clear wins
        wr(3'd1, 0);
        wr(3'd2, 1);
        wr(3'd6, 1);
        rd(3'd4, d); check("R10 set beats clear", d, 1);
        wr(3'd2, 0);
        wr(3'd6, 1);

        // R7: wait-for-trigger
        wr(3'd0, 32'h0A);
        wr(3'd1, 3);
        wr(3'd2, 1);
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (trig_out) quiet++;
        end
        check("R7 no timeout while armed", quiet, 0);
        rd(3'd7, d); check("R7 count held", d, 3);
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
        wait_trig(k);
        check("R7 period after trigger", k, 4);
        wr(3'd2, 0);

        // R12: snapshot of the free-running count
        wr(3'd0, 32'h12);
        wr(3'd1, 3);
        wr(3'd2, 1);
        rd(3'd7, d); check("R12 snapshot before timeout", d, 0);
        wait_trig(k);
        rd(3'd7, d); check("R12 first snapshot", d, 3);
        wait_trig(k);
        rd(3'd7, d); check("R12 second snapshot", d, 7);
        wr(3'd2, 0);

        // R13: mode 0 freezes the counter
        wr(3'd0, 32'h00);
        wr(3'd1, 4);
        wr(3'd2, 1);
        quiet = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (trig_out) quiet++;
        end
        check("R13 no timeout", quiet, 0);
        rd(3'd7, d); check("R13 frozen value", d, 4);
        wr(3'd2, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule